// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Short-Cycle Length

This block is the digital control of a 16-bit successive-approximation converter. It waits for a start pulse and begins a conversion on the pulse's falling edge. It then raises a busy flag and lets a gated conversion clock run. On each rising edge of that clock it settles one bit, working from the most significant bit down. The analog side is reduced to a single comparator input. That input reports whether the trial value presented by the result register is larger than the sampled input.

The result register holds the code in complemented, active-low form. A trial bit is driven to 0 and an inactive bit rests at 1. This gives complementary binary for unipolar ranges and complementary offset binary for bipolar ranges; the offset itself is analog. A short-cycle length, sampled when each conversion starts, can end the conversion after 8, 10, 12, 13, 14, 15 or 16 bits. Any shorter run leaves its unconverted low bits inactive. When the last decision is made, busy drops and the gated clock parks low. The final result is already in the register one system cycle before busy falls, so a consumer can capture it on the busy falling edge.

Top module: `sar_seq`

## Requirements
- R1: While reset is held and directly after it, busy_o is 0, gclk_o is 0 and every bit of data_o is 1.
- R2: A falling edge of start_i while busy_o is 0 raises busy_o within 8 clock cycles, and sets every bit of data_o to 1 at that point.
- R3: gclk_o is 0 whenever busy_o is 0.
- R4: In a conversion of N bits, gclk_o has exactly N+1 rising edges while busy_o is high. data_o changes only on a gclk_o rising edge or when a conversion starts.
- R5: At gated-clock step 0, data_o bit 15 is driven to 0 as the trial. At step k (1..N), bit 16-k is decided: it returns to 1 when cmp_i is 1, and stays 0 otherwise. If k<N, bit 15-k is also driven to 0 as the next trial. cmp_i is 1 when the true code ~data_o is greater than the input.
- R6: When busy_o falls, data_o equals ~(V & M). Here V is the input value and M keeps the top N bits. data_o then holds that value until the next conversion starts.
- R7: A short-cycle length N of 8, 10, 12, 13, 14, 15 or 16 ends the conversion after the bit-N decision. Data bits below the top N stay 1.
- R8: Any other short_len_i value is treated as 16.
- R9: short_len_i is sampled only when a conversion starts. Changing it during a conversion has no effect on that conversion.
- R10: A falling edge of start_i while busy_o is 1 is ignored. The running conversion completes normally, and no new conversion follows it.
- R11: data_o is stable on the clock cycle in which busy_o falls. The last decision is written one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request; a conversion starts on its falling edge |
| cmp_i | input | 1 | Comparator decision; 1 means the trial value exceeds the input |
| short_len_i | input | 5 | Requested conversion length in bits |
| busy_o | output | 1 | High while a conversion is in progress |
| gclk_o | output | 1 | Gated conversion clock; parked low when idle |
| data_o | output | 16 | Result register, complemented (active-low) code |

## Verification
The assertions assume the following about the inputs:
- start_i is synchronous to clk, or passes through the synchronizer cleanly, and each high or low phase lasts at least one cycle.
- cmp_i is settled by the gated-clock rising edge that samples it.
- short_len_i is stable at the moment a conversion is accepted.

The bench derives cmp_i from a comparison between the true code ~data_o and an ideal input value. Each start pulse lasts several cycles. The bench changes short_len_i and pulses start_i during a conversion only after busy_o is already high. It waits for busy_o to fall and for an idle gap before the next request.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Map a requested conversion length onto the supported set; anything
    // outside it selects the full width.
    function automatic int unsigned fix_len(input int unsigned req,
                                            input int unsigned width);
        if (req == 0 || req > width) begin
            return width;
        end
        if (req == width || req == width - 1 || req == width - 2 ||
            req == width - 3 || req == width - 4 || req == width - 6 ||
            req == width - 8) begin
            return req;
        end
        return width;
    endfunction

endpackage

// File: rtl/sar_start_det.sv
module sar_start_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   last_d, last_q;

    always_comb begin
        sync_d[0] = start_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        last_d = sync_q[SYNC_STAGES-1];
        fall_o = last_q & ~sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    // R2: a detected edge is a single-cycle pulse
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sar_gclk_gen.sv
module sar_gclk_gen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic gclk_o,
    output logic rise_o
);
    localparam int CW = $clog2(CLK_DIV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          gclk;
    } gen_t;

    gen_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d    = s_q;
        wrap   = (s_q.cnt == CW'(CLK_DIV - 1));
        rise_o = run_i && wrap && !s_q.gclk;
        if (!run_i) begin
            s_d.cnt  = '0;
            s_d.gclk = 1'b0;
        end else if (wrap) begin
            s_d.cnt  = '0;
            s_d.gclk = ~s_q.gclk;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gclk_o = s_q.gclk;

    // R3: once run is withdrawn the clock is parked low on the next edge
    a_r3_park_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !gclk_o);

    // R4: an announced rise is followed by the clock being high
    a_r4_rise_seen: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> gclk_o);

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              trial_en_i,
    input  logic [IDX_W-1:0]  trial_idx_i,
    input  logic              dec_en_i,
    input  logic [IDX_W-1:0]  dec_idx_i,
    input  logic              revert_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (init_i) begin
            data_d = '1;
        end else begin
            for (int i = 0; i < DATA_W; i++) begin
                if (dec_en_i && dec_idx_i == IDX_W'(i)) begin
                    data_d[i] = revert_i;
                end
                if (trial_en_i && trial_idx_i == IDX_W'(i)) begin
                    data_d[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit_chk
        // R5: a decision leaves the bit at 1 on revert, 0 on keep
        a_r5_decide: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en_i && !init_i && dec_idx_i == IDX_W'(g)) |=>
                (data_q[g] == $past(revert_i)));
        // R5: a trial forces the bit low
        a_r5_trial: assert property (@(posedge clk) disable iff (!rst_n)
            (trial_en_i && !init_i && trial_idx_i == IDX_W'(g)) |=>
                !data_q[g]);
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    input  logic [LEN_W-1:0]  short_len_i,
    output logic              busy_o,
    output logic              gclk_o,
    output logic [DATA_W-1:0] data_o
);
    import sar_pkg::*;

    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [LEN_W-1:0] step;
        logic [LEN_W-1:0] len;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic             start_fall;
    logic             start_acc;
    logic             gclk_rise;
    logic             run;
    logic             trial_en;
    logic             dec_en;
    logic [IDX_W-1:0] trial_idx;
    logic [IDX_W-1:0] dec_idx;

    sar_start_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .fall_o (start_fall)
    );

    assign run = c_q.busy && !c_q.done;

    sar_gclk_gen #(
        .CLK_DIV(CLK_DIV)
    ) u_gclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .gclk_o(gclk_o),
        .rise_o(gclk_rise)
    );

    always_comb begin
        c_d       = c_q;
        start_acc = start_fall && !c_q.busy;
        trial_en  = 1'b0;
        dec_en    = 1'b0;
        trial_idx = IDX_W'(DATA_W - 1 - int'(c_q.step));
        dec_idx   = IDX_W'(DATA_W - int'(c_q.step));
        if (start_acc) begin
            c_d.busy = 1'b1;
            c_d.done = 1'b0;
            c_d.step = '0;
            c_d.len  = LEN_W'(fix_len(int'(short_len_i), DATA_W));
        end else if (c_q.busy && c_q.done) begin
            c_d.busy = 1'b0;
            c_d.done = 1'b0;
        end else if (c_q.busy && gclk_rise) begin
            dec_en   = (c_q.step != '0);
            trial_en = (c_q.step < c_q.len);
            c_d.done = (c_q.step == c_q.len);
            c_d.step = c_q.step + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    sar_bit_reg #(
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (start_acc),
        .trial_en_i (trial_en),
        .trial_idx_i(trial_idx),
        .dec_en_i   (dec_en),
        .dec_idx_i  (dec_idx),
        .revert_i   (cmp_i),
        .data_o     (data_o)
    );

    assign busy_o = c_q.busy;

    // R2: an accepted start edge raises busy on the next edge
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && !busy_o) |=> busy_o);

    // R3: the gated clock is low whenever the block is idle
    a_r3_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !gclk_o);

    // R4: the register moves only on a gated-clock rise or a start
    a_r4_update_src: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> $past(gclk_rise || start_acc));

    // R6: the result is held while idle
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(data_o));

    // R7: busy falls only after the step of the final decision
    a_r7_stop_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (c_q.step == c_q.len + LEN_W'(1)));

    // R8: the active length is always a supported one
    a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (c_q.len >= LEN_W'(DATA_W - 8) && c_q.len <= LEN_W'(DATA_W)));

    // R9: the length is frozen for the whole conversion
    a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !c_q.done) |=> $stable(c_q.len));

    // R10: a start edge during a conversion does not restart it
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && busy_o && c_q.step != '0) |=> (c_q.step != '0));

    // R11: data is already final in the cycle busy falls
    a_r11_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $stable(data_o));

endmodule

// File: tb/tb_sar_seq.sv
`timescale 1ns/1ps
module tb_sar_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        cmp_i;
    logic [4:0]  short_len_i;
    logic        busy_o;
    logic        gclk_o;
    logic [15:0] data_o;
    logic [15:0] vin;
    logic [15:0] true_code;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [15:0] q_data[$];
    int          q_rise[$];

    always #4 clk = ~clk;

    sar_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .short_len_i(short_len_i),
        .busy_o     (busy_o),
        .gclk_o     (gclk_o),
        .data_o     (data_o)
    );

    // Ideal comparator: trial value above the input means revert
    assign true_code = ~data_o;
    assign cmp_i     = (true_code > vin);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int n);
        if (n == 8 || n == 10 || n == 12 || n == 13 || n == 14 || n == 15 || n == 16)
            return n;
        return 16;
    endfunction

    // Monitor: counts gated-clock rises per conversion, compares at busy fall
    logic prev_busy = 1'b0;
    logic prev_gclk = 1'b0;
    int   rises     = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy_o && gclk_o)
                check(1'b0, "R3 gclk while idle", {31'd0, gclk_o}, 32'd0);
            if (busy_o && !prev_busy) rises = 0;
            if (gclk_o && !prev_gclk) rises++;
            if (!busy_o && prev_busy) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R10 unexpected conversion", 32'd1, 32'd0);
                end else begin
                    logic [15:0] ed;
                    int          er;
                    ed = q_data.pop_front();
                    er = q_rise.pop_front();
                    check(data_o == ed, "R5/R6/R7 result", {16'd0, data_o}, {16'd0, ed});
                    check(rises == er, "R4 gclk rise count", rises, er);
                end
            end
        end
        prev_busy = busy_o;
        prev_gclk = gclk_o;
    end

    task automatic convert(input logic [15:0] v, input logic [4:0] n,
                           input bit chg_len, input bit extra_start, input string tag);
        int          ne;
        int          t;
        logic [15:0] mask;
        logic [15:0] exp;
        ne   = eff_len(int'(n));
        mask = 16'hFFFF << (16 - ne);
        exp  = ~(v & mask);
        vin         = v;
        short_len_i = n;
        q_data.push_back(exp);
        q_rise.push_back(ne + 1);
        @(negedge clk) start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        t = 0;
        while (!busy_o && t < 8) begin
            @(negedge clk);
            t++;
        end
        check(busy_o == 1'b1, {"R2 busy after start ", tag}, {31'd0, busy_o}, 32'd1);
        check(data_o == 16'hFFFF || t > 0, {"R2 init ", tag}, {16'd0, data_o}, 32'hFFFF);
        if (chg_len) begin
            repeat (4) @(negedge clk);
            short_len_i = (n == 5'd8) ? 5'd16 : 5'd8;
        end
        if (extra_start) begin
            repeat (6) @(negedge clk);
            start_i = 1'b1;
            repeat (2) @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (busy_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (10) @(negedge clk);
        check(busy_o == 1'b0, {"R10 stays idle ", tag}, {31'd0, busy_o}, 32'd0);
        check(data_o == exp, {"R6 idle hold ", tag}, {16'd0, data_o}, {16'd0, exp});
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        start_i     = 1'b0;
        short_len_i = 5'd16;
        vin         = 16'h0000;
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0, "R1 busy in reset", {31'd0, busy_o}, 32'd0);
        check(gclk_o == 1'b0, "R1 gclk in reset", {31'd0, gclk_o}, 32'd0);
        check(data_o == 16'hFFFF, "R1 data in reset", {16'd0, data_o}, 32'hFFFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && gclk_o == 1'b0 && data_o == 16'hFFFF,
              "R1 after reset", {15'd0, busy_o, gclk_o, data_o}, 32'h0000FFFF);

        convert(16'h9885, 5'd16, 1'b0, 1'b0, "full mid");      // R5 R6
        convert(16'h0000, 5'd16, 1'b0, 1'b0, "zero");
        convert(16'hFFFF, 5'd16, 1'b0, 1'b0, "full scale");
        convert(16'h8000, 5'd16, 1'b0, 1'b0, "half");
        convert(16'h7FFF, 5'd16, 1'b0, 1'b0, "below half");
        convert(16'hA5C3, 5'd8,  1'b0, 1'b0, "short 8");       // R7
        convert(16'hA5C3, 5'd10, 1'b0, 1'b0, "short 10");
        convert(16'h5A3C, 5'd12, 1'b0, 1'b0, "short 12");
        convert(16'h5A3F, 5'd13, 1'b0, 1'b0, "short 13");
        convert(16'hFFFF, 5'd14, 1'b0, 1'b0, "short 14");
        convert(16'h1237, 5'd15, 1'b0, 1'b0, "short 15");
        convert(16'hC3A7, 5'd9,  1'b0, 1'b0, "invalid 9");     // R8
        convert(16'h3C5B, 5'd0,  1'b0, 1'b0, "invalid 0");
        convert(16'h6E19, 5'd31, 1'b0, 1'b0, "invalid 31");
        convert(16'hB7E1, 5'd8,  1'b1, 1'b0, "len change 8");  // R9
        convert(16'hB7E1, 5'd16, 1'b1, 1'b0, "len change 16");
        convert(16'h4D2B, 5'd16, 1'b0, 1'b1, "restart ignored"); // R10 R11
        convert(16'h4D2B, 5'd10, 1'b0, 1'b1, "restart short");

        check(q_data.size() == 0, "R6 all results seen", q_data.size(), 32'd0);
        finish_run();
    end

endmodule